// File: doc/BRIEF.md
# Register File with Sub-Register Access

This block holds eight 32-bit general-purpose registers that can be reached at three widths. A port can address a whole register, its low 16 bits, or one byte of that low half: either bits 7:0 or bits 15:8. Byte lanes exist only on registers 0 to 3. Registers 4 to 7 offer only the whole-word and half-word views. Each register can hold a data word or an address. The block attaches no meaning to the contents.

There are two combinational read ports and one synchronous write port. Each port carries a register index and a 2-bit access selector. A read returns the selected field in the low bits of its output, with zeros above it. A half-word or byte write merges into the register, so every bit outside the addressed field keeps its old value. A byte request to a register without byte lanes raises that port's illegal flag. An illegal write changes nothing.

Top module: `gpr_subword_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero, so every read view of every register returns 0 after reset.
- R2: Registers are indexed 0 to 7. A whole-word write followed by a whole-word read of the same index returns the written value. Both read ports select their register independently.
- R3: The access selector encoding is fixed: 2'b00 is the whole 32-bit word, 2'b01 is bits 15:0, 2'b10 is the byte at bits 7:0, and 2'b11 is the byte at bits 15:8.
- R4: Reads are zero-extended. A half-word read returns bits 15:0 in rd_data[15:0] with zeros above. A byte read returns the addressed byte in rd_data[7:0] with zeros above.
- R5: A half-word write replaces bits 15:0 with wr_data[15:0] and leaves bits 31:16 unchanged.
- R6: A byte write to index 0 to 3 replaces only the addressed byte with wr_data[7:0]. Selector 2'b10 targets bits 7:0 and selector 2'b11 targets bits 15:8. All other bits are kept.
- R7: On a read port, a byte selector (2'b10 or 2'b11) with index 4 to 7 drives that port's illegal flag high and its data output to 0. Every other combination leaves the flag low.
- R8: On the write port, a byte selector with index 4 to 7 drives wr_illegal high, and the write leaves every register unchanged.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old contents, and the new value is visible after the clock edge.
- R10: While wr_en is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_sel | input | 2 | Write access selector |
| wr_data | input | 32 | Write data; only the addressed field is used |
| wr_illegal | output | 1 | Write request addresses a missing byte lane |
| rd0_idx | input | 3 | Register index, read port 0 |
| rd0_sel | input | 2 | Access selector, read port 0 |
| rd0_data | output | 32 | Zero-extended field, read port 0 |
| rd0_illegal | output | 1 | Read port 0 addresses a missing byte lane |
| rd1_idx | input | 3 | Register index, read port 1 |
| rd1_sel | input | 2 | Access selector, read port 1 |
| rd1_data | output | 32 | Zero-extended field, read port 1 |
| rd1_illegal | output | 1 | Read port 1 addresses a missing byte lane |

## Verification
Read data and all illegal flags are combinational. The bench drives its inputs on the falling edge and samples one nanosecond later, before the next rising edge. A write takes effect on the first rising edge after it is presented. For that reason the same-cycle sample of the target must still show the old value, and the new value is checked after the following falling edge. The sweep covers every index, selector and several data patterns. After each write it compares all four views against a model the bench updates arithmetically.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        ACC_WORD    = 2'b00,
        ACC_HALF    = 2'b01,
        ACC_BYTE_LO = 2'b10,
        ACC_BYTE_HI = 2'b11
    } acc_e;

    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/gpr_lane_check.sv
module gpr_lane_check
    import gpr_pkg::*;
#(
    parameter int IDX_W          = 3,
    parameter int BYTE_LANE_REGS = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  acc_e             acc,
    output logic             illegal
);
    localparam logic [IDX_W:0] LANE_LIMIT = BYTE_LANE_REGS[IDX_W:0];

    logic is_byte;

    always_comb begin
        is_byte = (acc == ACC_BYTE_LO) || (acc == ACC_BYTE_HI);
        illegal = is_byte && ({1'b0, idx} >= LANE_LIMIT);
    end
endmodule

// File: rtl/gpr_read_view.sv
module gpr_read_view
    import gpr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] word,
    input  acc_e            acc,
    input  logic            illegal,
    output logic [XLEN-1:0] field
);
    always_comb begin
        field = '0;
        if (!illegal) begin
            unique case (acc)
                ACC_WORD:    field = word;
                ACC_HALF:    field[HALF_W-1:0] = word[HALF_W-1:0];
                ACC_BYTE_LO: field[BYTE_W-1:0] = word[BYTE_W-1:0];
                ACC_BYTE_HI: field[BYTE_W-1:0] = word[HALF_W-1:BYTE_W];
                default:     field = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] wdata,
    input  acc_e            acc,
    output logic [XLEN-1:0] merged
);
    always_comb begin
        merged = old_word;
        unique case (acc)
            ACC_WORD:    merged = wdata;
            ACC_HALF:    merged[HALF_W-1:0] = wdata[HALF_W-1:0];
            ACC_BYTE_LO: merged[BYTE_W-1:0] = wdata[BYTE_W-1:0];
            ACC_BYTE_HI: merged[HALF_W-1:BYTE_W] = wdata[BYTE_W-1:0];
            default:     merged = old_word;
        endcase
    end
endmodule

// File: rtl/gpr_subword_file.sv
module gpr_subword_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS       = 8,
    parameter int XLEN           = 32,
    parameter int BYTE_LANE_REGS = 4,
    localparam int IDX_W         = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_illegal,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_sel,
    output logic [XLEN-1:0]  rd0_data,
    output logic             rd0_illegal,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_sel,
    output logic [XLEN-1:0]  rd1_data,
    output logic             rd1_illegal
);
    localparam int NUM_RD = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] regs;
    } state_t;

    state_t state_d, state_q;

    // Read ports gathered into arrays so they can share one generate loop.
    logic [IDX_W-1:0] rd_idx  [NUM_RD];
    acc_e             rd_acc  [NUM_RD];
    logic [XLEN-1:0]  rd_word [NUM_RD];
    logic [XLEN-1:0]  rd_field[NUM_RD];
    logic             rd_bad  [NUM_RD];

    always_comb begin
        rd_idx[0]   = rd0_idx;
        rd_idx[1]   = rd1_idx;
        rd_acc[0]   = acc_e'(rd0_sel);
        rd_acc[1]   = acc_e'(rd1_sel);
        rd0_data    = rd_field[0];
        rd1_data    = rd_field[1];
        rd0_illegal = rd_bad[0];
        rd1_illegal = rd_bad[1];
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_word[p] = state_q.regs[rd_idx[p]];

        gpr_lane_check #(
            .IDX_W          (IDX_W),
            .BYTE_LANE_REGS (BYTE_LANE_REGS)
        ) u_chk (
            .idx     (rd_idx[p]),
            .acc     (rd_acc[p]),
            .illegal (rd_bad[p])
        );

        gpr_read_view #(.XLEN(XLEN)) u_view (
            .word    (rd_word[p]),
            .acc     (rd_acc[p]),
            .illegal (rd_bad[p]),
            .field   (rd_field[p])
        );
    end

    // Write path: legality test, then merge into the old contents.
    acc_e            wr_acc;
    logic [XLEN-1:0] wr_old;
    logic [XLEN-1:0] wr_merged;

    assign wr_acc = acc_e'(wr_sel);
    assign wr_old = state_q.regs[wr_idx];

    gpr_lane_check #(
        .IDX_W          (IDX_W),
        .BYTE_LANE_REGS (BYTE_LANE_REGS)
    ) u_wr_chk (
        .idx     (wr_idx),
        .acc     (wr_acc),
        .illegal (wr_illegal)
    );

    gpr_write_merge #(.XLEN(XLEN)) u_merge (
        .old_word (wr_old),
        .wdata    (wr_data),
        .acc      (wr_acc),
        .merged   (wr_merged)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en && !wr_illegal) begin
            state_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/gpr_subword_file_chk.sv
module gpr_subword_file_chk #(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    parameter int IDX_W    = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic [1:0]                    wr_sel,
    input logic [XLEN-1:0]               wr_data,
    input logic                          wr_illegal,
    input logic [1:0]                    rd0_sel,
    input logic [XLEN-1:0]               rd0_data,
    input logic                          rd0_illegal,
    input logic [1:0]                    rd1_sel,
    input logic [XLEN-1:0]               rd1_data,
    input logic                          rd1_illegal,
    input logic [NUM_REGS-1:0][XLEN-1:0] regs_q
);
    logic [XLEN-1:0] target_word;
    assign target_word = regs_q[wr_idx];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (regs_q == '0)); // R1

    AST_WORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b00) |=> (regs_q[$past(wr_idx)] == $past(wr_data))); // R2

    AST_HALF_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'b01)
        |=> (regs_q[$past(wr_idx)][XLEN-1:16] == $past(target_word[XLEN-1:16]))); // R5

    AST_RD0_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rd0_sel != 2'b00) |-> (rd0_data[XLEN-1:16] == '0)); // R4

    AST_RD1_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rd1_sel != 2'b00) |-> (rd1_data[XLEN-1:16] == '0)); // R4

    AST_RD0_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd0_illegal |-> (rd0_data == '0)); // R7

    AST_RD1_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd1_illegal |-> (rd1_data == '0)); // R7

    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_illegal) |=> $stable(regs_q)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q)); // R10
endmodule

bind gpr_subword_file gpr_subword_file_chk #(
    .NUM_REGS (NUM_REGS),
    .XLEN     (XLEN),
    .IDX_W    (IDX_W)
) u_gpr_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .wr_illegal  (wr_illegal),
    .rd0_sel     (rd0_sel),
    .rd0_data    (rd0_data),
    .rd0_illegal (rd0_illegal),
    .rd1_sel     (rd1_sel),
    .rd1_data    (rd1_data),
    .rd1_illegal (rd1_illegal),
    .regs_q      (state_q.regs)
);

// File: tb/gpr_subword_file_bench.sv
`timescale 1ns/1ps
module gpr_subword_file_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        wr_illegal;
    logic [2:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_sel, rd1_sel;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [31:0] model [8];

    always #4 clk = ~clk;

    gpr_subword_file u_gpr_subword_file (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_sel(rd0_sel), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_sel(rd1_sel), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    function automatic logic bad_lane(input int idx, input logic [1:0] sel);
        return sel[1] && (idx >= 4);
    endfunction

    function automatic logic [31:0] view(input logic [31:0] w, input int idx, input logic [1:0] sel);
        if (bad_lane(idx, sel)) return 32'd0;
        case (sel)
            2'b00:   return w;
            2'b01:   return w & 32'h0000_FFFF;
            2'b10:   return w & 32'h0000_00FF;
            default: return (w >> 8) & 32'h0000_00FF;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] w, input logic [31:0] d, input logic [1:0] sel);
        case (sel)
            2'b00:   return d;
            2'b01:   return (w & 32'hFFFF_0000) | (d & 32'h0000_FFFF);
            2'b10:   return (w & 32'hFFFF_FF00) | (d & 32'h0000_00FF);
            default: return (w & 32'hFFFF_00FF) | ((d & 32'h0000_00FF) << 8);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Read one register through both ports, every selector, and compare.
    task automatic read_all_views(input int idx, input string tag);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            rd0_idx = 3'(idx); rd0_sel = 2'(s);
            rd1_idx = 3'(idx); rd1_sel = 2'(3 - s);
            #1;
            check({tag, " rd0 data"}, rd0_data, view(model[idx], idx, 2'(s)));
            check({tag, " rd1 data"}, rd1_data, view(model[idx], idx, 2'(3 - s)));
            check({tag, " R7 rd0 flag"}, {31'd0, rd0_illegal}, {31'd0, bad_lane(idx, 2'(s))});
            check({tag, " R7 rd1 flag"}, {31'd0, rd1_illegal}, {31'd0, bad_lane(idx, 2'(3 - s))});
        end
    endtask

    task automatic do_write(input int idx, input logic [1:0] sel, input logic [31:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_sel = sel; wr_data = d;
        rd0_idx = 3'(idx); rd0_sel = 2'b00;
        #1;
        check({tag, " R8 wr flag"}, {31'd0, wr_illegal}, {31'd0, bad_lane(idx, sel)});
        check("R9 old value before edge", rd0_data, model[idx]);
        @(posedge clk);
        if (!bad_lane(idx, sel)) model[idx] = merge(model[idx], d, sel);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check({tag, " after edge"}, rd0_data, model[idx]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_sel = '0; wr_data = '0;
        rd0_idx = '0; rd0_sel = '0; rd1_idx = '0; rd1_sel = '0;
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state through every view
        for (int i = 0; i < 8; i++) read_all_views(i, "R1 reset");

        // R2 whole-word writes with distinct values, both ports independent
        for (int i = 0; i < 8; i++)
            do_write(i, 2'b00, 32'hA5C3_0F00 ^ (32'h0101_0101 * (i + 1)), "R2 word");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd0_idx = 3'(i); rd0_sel = 2'b00; rd1_idx = 3'(7 - i); rd1_sel = 2'b00;
            #1;
            check("R2 rd0 independent", rd0_data, model[i]);
            check("R2 rd1 independent", rd1_data, model[7 - i]);
        end

        // R3 R4 R5 R6 R7 R8: sweep index x selector x pattern
        for (int i = 0; i < 8; i++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 3; k++) begin
                    do_write(i, 2'(s), 32'h9E37_79B9 * (i * 12 + s * 3 + k + 1), "R3 R5 R6 sweep");
                    read_all_views(i, "R4 R6 views");
                end

        // R6 explicit lanes on register 2
        do_write(2, 2'b00, 32'h1122_3344, "R6 setup");
        do_write(2, 2'b11, 32'hFFFF_FFAB, "R6 high byte");
        check("R6 high byte lane", model[2], 32'h1122_AB44);
        do_write(2, 2'b10, 32'h0000_00CD, "R6 low byte");
        read_all_views(2, "R6 lanes");

        // R8 illegal byte write to register 5 leaves it intact
        do_write(5, 2'b00, 32'hDEAD_BEEF, "R8 setup");
        do_write(5, 2'b10, 32'h0000_0011, "R8 bad lo");
        do_write(5, 2'b11, 32'h0000_0022, "R8 bad hi");
        check("R8 register 5 intact", model[5], 32'hDEAD_BEEF);

        // R10 wr_en low with data presented
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd3; wr_sel = 2'b00; wr_data = 32'h0BAD_F00D;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd0_idx = 3'd3; rd0_sel = 2'b00;
        #1;
        check("R10 idle no change", rd0_data, model[3]);

        // R1 reset again clears non-zero contents
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
        for (int i = 0; i < 8; i++) read_all_views(i, "R1 re-reset");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule